// File: doc/BRIEF.md
# Quadlet Nibble-Serial CRC-16 Generator

This block computes a 16-bit check value over a run of 32-bit quadlets and packs it into a header word for self-describing register tables. A typical user is a table such as a node topology list or a speed table. Such a table starts with a header quadlet whose upper half gives the number of quadlets the check covers and whose lower half holds the check value.

A one-cycle `start` pulse samples a length mode and a count, clears the accumulator and opens the input. Quadlets arrive through a valid/ready handshake. Each quadlet is folded into the accumulator four bits per clock, starting with its most significant nibble. A quadlet therefore occupies the engine for eight clocks, and `inReady` stays low for the seven clocks after a quadlet is taken. Once the last covered quadlet is finished, `done` pulses for one cycle. `crcOut` and `headerOut` take the result in that same cycle and hold it until the next result.

Three length modes set the covered length. In raw mode the count is used as is. In list mode the covered length is the count plus two. In fixed mode the covered length is a constant 0x3F1 quadlets and the count is not used.

Top module: `qcrc_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `inReady`, `done`, `crcOut` and `headerOut` are all zero.
- R2: A `start` pulse with a nonzero covered length raises `inReady` in the next cycle. `inReady` then stays high, and nothing is accepted, for as long as `inValid` is low.
- R3: The accumulator starts at zero. Each quadlet is taken as eight nibbles, from bits 31:28 down to bits 3:0. For each nibble, s = (acc[15:12] XOR nibble) and acc becomes ((acc << 4) XOR (s << 12) XOR (s << 5) XOR s), kept to 16 bits. For example, the single quadlet 0x00000001 gives 0x1021.
- R4: A quadlet is taken on a clock edge where `inValid` and `inReady` are both high. `inReady` is then low for exactly 7 cycles, so each quadlet costs 8 cycles.
- R5: `inValid` and `inData` have no effect while `inReady` is low.
- R6: `done` is high for exactly one cycle, the cycle after the last nibble of the last covered quadlet. `crcOut` changes only in a cycle where `done` is high, and it holds its value otherwise.
- R7: When `done` is high, `headerOut` bits 31:16 hold the covered length and bits 15:0 equal `crcOut`.
- R8: The length mode is encoded as follows: `lenMode` 2'b00 and 2'b11 select raw mode, where the covered length is `wordCount`. 2'b01 selects list mode, where it is `wordCount` + 2 (modulo 2^16).
- R9: `lenMode` 2'b10 selects fixed mode. The covered length is then 0x3F1 whatever `wordCount` is.
- R10: A covered length of zero makes `done` high in the cycle after `start`, with `crcOut` = 0x0000 and `headerOut` = 0x00000000. `inReady` stays low.
- R11: A `start` pulse during a computation abandons it. The accumulator restarts from zero and no `done` is given for the abandoned run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new computation |
| lenMode | input | 2 | Covered-length mode, sampled with `start` |
| wordCount | input | 16 | Count used by raw and list modes, sampled with `start` |
| inValid | input | 1 | `inData` holds a quadlet |
| inData | input | 32 | Quadlet to fold in |
| inReady | output | 1 | The block can take a quadlet this cycle |
| done | output | 1 | One-cycle pulse when the result is ready |
| crcOut | output | 16 | Most recent check value |
| headerOut | output | 32 | Most recent header: {covered length, check value} |

## Verification
The single quadlet 0x00000001 gives the hand-derived value 0x1021. This pins down the equation and the nibble order independently of any model. Multi-quadlet runs in all three length modes, including the full 0x3F1-quadlet fixed run, are compared every cycle against a behavioural model. They tell apart the three ways of deriving the length and show that the accumulator carries across quadlet boundaries.

A run with `inValid` held high and `inData` changing every cycle while the engine is busy would expose any input taken mid-quadlet. A run with stalls would expose a handshake that does not wait. Zero-length starts and restarts issued both mid-nibble and while waiting separate a clean restart from a leftover accumulator.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;

  localparam int CRC_W = 16;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    LEN_RAW     = 2'b00,
    LEN_LIST    = 2'b01,
    LEN_FIXED   = 2'b10,
    LEN_RAW_ALT = 2'b11
  } lenMode_e;

  typedef struct packed {
    logic clearAcc;
    logic takeWord;
    logic shiftNib;
    logic finish;
    logic zeroFinish;
  } crcStrobe_t;

  // One nibble of the shift-and-xor check update.
  function automatic logic [CRC_W-1:0] nibStep(input logic [CRC_W-1:0] acc,
                                               input logic [NIB_W-1:0] nib);
    logic [NIB_W-1:0] s;
    logic [CRC_W-1:0] sWide;
    s     = acc[CRC_W-1 -: NIB_W] ^ nib;
    sWide = CRC_W'(s);
    return (acc << NIB_W) ^ (sWide << 12) ^ (sWide << 5) ^ sWide;
  endfunction

endpackage

// File: rtl/qcrc_ctrl.sv
module qcrc_ctrl
  import qcrc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NIBS       = 8,
  parameter int FIXED_LEN  = 'h3F1,
  parameter int LIST_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       lenMode,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             inValid,
  output logic             inReady,
  output logic             done,
  output logic [CNT_W-1:0] hdrLen,
  output crcStrobe_t       stb
);

  localparam int NC_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [NC_W-1:0] LAST_NIB = NC_W'(NIBS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT} ctrlState_e;

  ctrlState_e       state;
  logic [CNT_W-1:0] remaining;
  logic [NC_W-1:0]  nibCnt;
  logic [CNT_W-1:0] lenNow;
  logic             lastNib;
  logic             lastWord;

  always_comb begin
    case (lenMode_e'(lenMode))
      LEN_LIST:  lenNow = wordCount + CNT_W'(LIST_EXTRA);
      LEN_FIXED: lenNow = CNT_W'(FIXED_LEN);
      default:   lenNow = wordCount;
    endcase
  end

  assign lastNib  = (nibCnt == LAST_NIB);
  assign lastWord = (remaining == CNT_W'(1));
  assign inReady  = (state == ST_WAIT);

  always_comb begin
    stb            = '0;
    stb.clearAcc   = start;
    stb.zeroFinish = start && (lenNow == '0);
    stb.takeWord   = !start && (state == ST_WAIT) && inValid;
    stb.shiftNib   = !start && (state == ST_SHIFT);
    stb.finish     = stb.shiftNib && lastNib && lastWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      nibCnt    <= '0;
      hdrLen    <= '0;
      done      <= 1'b0;
    end else begin
      done <= stb.finish || stb.zeroFinish;
      if (start) begin
        hdrLen    <= lenNow;
        remaining <= lenNow;
        nibCnt    <= '0;
        state     <= (lenNow == '0) ? ST_IDLE : ST_WAIT;
      end else begin
        case (state)
          ST_WAIT: begin
            if (inValid) begin
              nibCnt <= NC_W'(1);
              state  <= ST_SHIFT;
            end
          end
          ST_SHIFT: begin
            if (lastNib) begin
              nibCnt    <= '0;
              remaining <= remaining - CNT_W'(1);
              state     <= lastWord ? ST_IDLE : ST_WAIT;
            end else begin
              nibCnt <= nibCnt + NC_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/qcrc_dpath.sv
module qcrc_dpath
  import qcrc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  crcStrobe_t             stb,
  input  logic [WORD_W-1:0]      inData,
  input  logic [CNT_W-1:0]       hdrLen,
  output logic [CRC_W-1:0]       crcOut,
  output logic [CNT_W+CRC_W-1:0] headerOut
);

  logic [WORD_W-1:0] shReg;
  logic [CRC_W-1:0]  acc;
  logic [NIB_W-1:0]  topNib;
  logic [CRC_W-1:0]  stepped;

  assign topNib  = stb.takeWord ? inData[WORD_W-1 -: NIB_W] : shReg[WORD_W-1 -: NIB_W];
  assign stepped = nibStep(acc, topNib);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      acc       <= '0;
      crcOut    <= '0;
      headerOut <= '0;
    end else begin
      if (stb.clearAcc) begin
        acc <= '0;
      end else if (stb.takeWord) begin
        acc   <= stepped;
        shReg <= inData << NIB_W;
      end else if (stb.shiftNib) begin
        acc   <= stepped;
        shReg <= shReg << NIB_W;
      end
      if (stb.zeroFinish) begin
        crcOut    <= '0;
        headerOut <= '0;
      end else if (stb.finish) begin
        crcOut    <= stepped;
        headerOut <= {hdrLen, stepped};
      end
    end
  end

endmodule

// File: rtl/qcrc_gen.sv
module qcrc_gen
  import qcrc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CNT_W     = 16,
  parameter int FIXED_LEN = 'h3F1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             lenMode,
  input  logic [CNT_W-1:0]       wordCount,
  input  logic                   inValid,
  input  logic [WORD_W-1:0]      inData,
  output logic                   inReady,
  output logic                   done,
  output logic [CRC_W-1:0]       crcOut,
  output logic [CNT_W+CRC_W-1:0] headerOut
);

  localparam int NIBS = WORD_W / NIB_W;

  crcStrobe_t       stb;
  logic [CNT_W-1:0] hdrLen;

  qcrc_ctrl #(
    .CNT_W(CNT_W), .NIBS(NIBS), .FIXED_LEN(FIXED_LEN), .LIST_EXTRA(2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lenMode(lenMode),
    .wordCount(wordCount), .inValid(inValid), .inReady(inReady),
    .done(done), .hdrLen(hdrLen), .stb(stb)
  );

  qcrc_dpath #(
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .hdrLen(hdrLen),
    .crcOut(crcOut), .headerOut(headerOut)
  );

endmodule

// File: rtl/qcrc_gen_chk.sv
module qcrc_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       lenMode,
  input logic [CNT_W-1:0] wordCount,
  input logic             inValid,
  input logic             inReady,
  input logic             done,
  input logic [15:0]      crcOut,
  input logic [CNT_W+15:0] headerOut
);

  // R4
  take_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !start) |=> !inReady);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(crcOut));

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && lenMode == 2'b00 && wordCount == '0) |=>
      (done && !inReady && crcOut == 16'h0 && headerOut == '0));

  // R2
  start_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && lenMode == 2'b10) |=> (inReady && !done));

  // R7
  header_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (headerOut[15:0] == crcOut));

endmodule

bind qcrc_gen qcrc_gen_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .lenMode(lenMode),
  .wordCount(wordCount), .inValid(inValid), .inReady(inReady),
  .done(done), .crcOut(crcOut), .headerOut(headerOut)
);

// File: tb/tb_qcrc_gen.sv
module tb_qcrc_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rstN = 0, start = 0, inValid = 0;
  logic [1:0]  lenMode = 0;
  logic [15:0] wordCount = 0;
  logic [31:0] inData = 0;
  logic        inReady, done;
  logic [15:0] crcOut;
  logic [31:0] headerOut;

  qcrc_gen dut (
    .clk(clk), .rstN(rstN), .start(start), .lenMode(lenMode),
    .wordCount(wordCount), .inValid(inValid), .inData(inData),
    .inReady(inReady), .done(done), .crcOut(crcOut), .headerOut(headerOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] refStep(input logic [15:0] a, input logic [3:0] n);
    int s, v;
    s = ((int'(a) >> 12) ^ int'(n)) & 15;
    v = (int'(a) << 4) ^ (s << 12) ^ (s << 5) ^ s;
    return v[15:0];
  endfunction

  function automatic logic [15:0] crcOf(input logic [31:0] ws[$]);
    logic [15:0] c = 0;
    foreach (ws[i])
      for (int sh = 28; sh >= 0; sh -= 4)
        c = refStep(c, 4'((ws[i] >> sh) & 32'hF));
    return c;
  endfunction

  function automatic int lenFor(input logic [1:0] m, input logic [15:0] c);
    case (m)
      2'b01:   return (int'(c) + 2) & 16'hFFFF;
      2'b10:   return 'h3F1;
      default: return int'(c);
    endcase
  endfunction

  // Behavioural reference, advanced on every rising edge.
  int          mPhase = 0, mNib = 0, mRem = 0, mLen = 0;
  logic [15:0] mAcc = 0, mCrc = 0;
  logic [31:0] mWord = 0, mHdr = 0;
  logic        mDone = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mNib = 0; mRem = 0; mLen = 0;
      mAcc = 0; mCrc = 0; mHdr = 0; mDone = 0;
    end else begin
      mDone = 0;
      if (start) begin
        mLen = lenFor(lenMode, wordCount);
        mAcc = 0; mRem = mLen;
        if (mLen == 0) begin
          mDone = 1; mCrc = 0; mHdr = 0; mPhase = 0;
        end else mPhase = 1;
      end else if (mPhase == 1) begin
        if (inValid) begin
          mWord = inData;
          mAcc = refStep(mAcc, mWord[31:28]);
          mNib = 1; mPhase = 2;
        end
      end else if (mPhase == 2) begin
        mAcc = refStep(mAcc, 4'((mWord >> (28 - 4 * mNib)) & 32'hF));
        mNib++;
        if (mNib == 8) begin
          mRem--;
          if (mRem == 0) begin
            mDone = 1; mCrc = mAcc; mHdr = {mLen[15:0], mAcc}; mPhase = 0;
          end else mPhase = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(inReady === (mPhase == 1), "R4", "inReady", 32'(inReady), 32'(mPhase == 1));
      check(done === mDone, "R6", "done", 32'(done), 32'(mDone));
      check(crcOut === mCrc, "R3", "crcOut", 32'(crcOut), 32'(mCrc));
      check(headerOut === mHdr, "R7", "headerOut", headerOut, mHdr);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic startRun(input logic [1:0] m, input logic [15:0] c);
    lenMode = m; wordCount = c; start = 1;
    tick();
    start = 0;
  endtask

  task automatic sendWord(input logic [31:0] w, input bit noisy);
    while (!inReady) begin
      inValid = noisy; inData = $urandom;
      tick();
    end
    inValid = 1; inData = w;
    tick();
    inValid = noisy;
    if (noisy) inData = $urandom;
  endtask

  task automatic waitDone(output bit got);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin got = 1; break; end
      tick();
    end
  endtask

  task automatic runCase(input logic [1:0] m, input logic [15:0] c,
                         input logic [31:0] ws[$], input bit noisy, input string req);
    bit got;
    logic [15:0] expCrc;
    logic [15:0] expLen;
    expCrc = crcOf(ws);
    expLen = 16'(lenFor(m, c));
    startRun(m, c);
    foreach (ws[i]) sendWord(ws[i], noisy);
    inValid = 0;
    waitDone(got);
    check(got, req, "done seen", 32'(got), 32'd1);
    check(crcOut == expCrc, req, "crc", 32'(crcOut), 32'(expCrc));
    check(headerOut == {expLen, expCrc}, req, "header", headerOut, {expLen, expCrc});
    tick();
    check(done == 0, "R6", "done after pulse", 32'(done), 32'd0);
    check(crcOut == expCrc, "R6", "crc held", 32'(crcOut), 32'(expCrc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] q[$];
    bit got;
    repeat (3) tick();
    // R1: outputs during reset
    check(inReady == 0 && done == 0, "R1", "ctl in reset", {inReady, done}, 0);
    check(crcOut == 0 && headerOut == 0, "R1", "data in reset", headerOut, 0);
    rstN = 1;
    tick();
    check(inReady == 0 && done == 0 && crcOut == 0 && headerOut == 0, "R1",
          "after release", {inReady, done, crcOut[13:0]}, 0);

    // R3: hand-derived vector
    q = {32'h00000001};
    runCase(2'b00, 16'd1, q, 0, "R3");
    check(crcOut == 16'h1021, "R3", "known vector", 32'(crcOut), 32'h1021);
    q = {32'h0, 32'h00000001};
    runCase(2'b11, 16'd2, q, 0, "R3");
    check(crcOut == 16'h1021, "R3", "zero lead word", 32'(crcOut), 32'h1021);

    // R7: raw mode, several words
    q = {32'hDEADBEEF, 32'h12345678, 32'hF0F0A5A5};
    runCase(2'b00, 16'd3, q, 0, "R7");

    // R5: noisy valid and data while busy
    q = {32'h0BADF00D, 32'h80000000, 32'hFFFFFFFF, 32'h00010203};
    runCase(2'b00, 16'd4, q, 1, "R5");

    // R8: list mode covers count+2
    q = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};
    runCase(2'b01, 16'd2, q, 0, "R8");

    // R2: stall before sending
    startRun(2'b00, 16'd1);
    repeat (5) begin
      check(inReady == 1 && done == 0, "R2", "stall ready", {inReady, done}, 2);
      tick();
    end
    sendWord(32'h00000001, 0);
    waitDone(got);
    check(got && crcOut == 16'h1021, "R2", "after stall", 32'(crcOut), 32'h1021);

    // R10: zero covered length
    startRun(2'b00, 16'd0);
    check(done == 1 && inReady == 0, "R10", "zero done", {inReady, done}, 1);
    check(crcOut == 0 && headerOut == 0, "R10", "zero result", headerOut, 0);
    tick();
    check(done == 0, "R10", "zero pulse ends", 32'(done), 0);
    startRun(2'b01, 16'hFFFE);
    check(done == 1 && headerOut == 0, "R10", "list wrap zero", headerOut, 0);
    tick();

    // R11: restart mid-nibble and while waiting
    startRun(2'b00, 16'd3);
    sendWord(32'hCAFEBABE, 0);
    repeat (3) tick();
    q = {32'h00000001};
    runCase(2'b00, 16'd1, q, 0, "R11");
    check(headerOut == 32'h00011021, "R11", "restart mid", headerOut, 32'h00011021);
    startRun(2'b00, 16'd2);
    sendWord(32'h76543210, 0);
    while (!inReady) tick();
    q = {32'h00000001};
    runCase(2'b00, 16'd1, q, 0, "R11");
    check(crcOut == 16'h1021, "R11", "restart waiting", 32'(crcOut), 32'h1021);

    // R9: fixed length, count ignored
    q = {};
    for (int i = 0; i < 'h3F1; i++) q.push_back(32'(i * 32'h9E3779B1));
    runCase(2'b10, 16'd5, q, 0, "R9");
    check(headerOut[31:16] == 16'h03F1, "R9", "fixed length", 32'(headerOut[31:16]), 32'h3F1);

    repeat (2) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule